// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a 32-bit flash bank. The bank is built from four byte-wide devices. All four share one 21-bit address bus and one set of output-enable and reset lines, and each device has its own write strobe. A single-beat command port accepts four kinds of request: program a word (with per-byte-lane enables), erase one 64 KB sector, erase the whole bank, or reset the devices.

For each request the sequencer generates the unlock and command bus cycles with write-strobe-controlled timing. Every timing minimum is a count of system clocks, worked out from the clock period and rounded up. It then polls the bank. A lane is finished once bit 7 of its byte reads back as the true written value. While the lane is busy, the devices return the complement of that bit.

When all enabled lanes have finished, the block reports a done mask. If the operation-level limit runs out first, it reports a timeout mask, pulses the reset line and waits out the recovery time. Host reads go straight through when the block is idle. During a sector erase, reads of any other sector are also served.

Top module: `flash_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `f_we_n` is 4'hF, `f_oe_n` and `f_rst_n` are 1, `rd_ack` is 0, and both status masks are 0.
- R2: A program request (`cmd_op`=0) writes four bus cycles on every lane whose `cmd_be` bit is set. The cycles are (UA1,UD1), (UA2,UD2), (UA1,CMD_PROG), and finally (`cmd_addr`, that lane's byte of `cmd_data`). Lane n is bits [8n+7:8n]. A lane whose enable bit is clear sees no write strobe.
- R3: Each write strobe stays low for at least ceil(T_WP_NS/CLK_PERIOD_NS) clocks. Consecutive strobes are separated by at least max(ceil(T_WPH_NS), ceil(T_WC_NS)-low, ceil(T_OEH_NS)) clocks high. The address does not change while the strobe is low.
- R4: A sector erase (`cmd_op`=1) issues six cycles: UD1, UD2, CMD_ERASE, UD1, UD2 on UA1/UA2/UA1/UA1/UA2, then CMD_SECT at the sector base address (`cmd_addr`[20:16] with the low 16 bits zero). A bank erase (`cmd_op`=2) issues the same cycles but ends with CMD_CHIP at UA1. Both use all four lanes.
- R5: After the last write, the block polls with output-enable reads at the command address. A lane is complete when its bit 7 reads equal to the written bit 7 (1 for erase). When all enabled lanes are complete, `st_done` pulses for one cycle with `st_done_mask` equal to the enabled lanes and `st_to_mask` equal to 0. This happens no earlier than the slowest lane finishes.
- R6: The first output-enable fall after a write is at least ceil(T_OEH_NS) clocks after the last strobe rises. Write strobe and output enable are never low together.
- R7: If the limit for the operation (TO_PROG_TK, TO_SECT_TK or TO_CHIP_TK ticks of TICK_NS) expires first, the block does the following in order. It sets `st_to_mask` to the enabled lanes that are not finished. It drives `f_rst_n` low for at least ceil(T_RP_NS) clocks with the bus idle. It waits ceil(T_READY_NS) clocks. It then pulses `st_done` with `st_done_mask` equal to the finished lanes.
- R8: A reset request (`cmd_op`=3) issues no write cycles. It makes the same reset pulse and recovery wait, then pulses `st_done` with `st_done_mask`=4'hF and `st_to_mask`=0.
- R9: A read (`rd_req` held with `rd_addr`) returns `f_dq_in` at `rd_addr` on `rd_data` with a one-cycle `rd_ack`. Reads are served when the block is idle. During sector-erase polling they are also served if `rd_addr`[20:16] differs from the erased sector. Otherwise they wait until the operation ends.
- R10: `cmd_ready` is 1 only when idle. A request presented while the block is busy has no effect on the bus cycles of the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request valid |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 bank erase, 3 device reset |
| cmd_addr | input | 21 | Word address (sector in bits 20:16) |
| cmd_data | input | 32 | Program data |
| cmd_be | input | 4 | Lanes to program |
| cmd_ready | output | 1 | Idle, request accepted |
| rd_req | input | 1 | Host read request, held until acknowledged |
| rd_addr | input | 21 | Host read address |
| rd_data | output | 32 | Read result |
| rd_ack | output | 1 | One-cycle read completion |
| st_done | output | 1 | One-cycle operation end pulse |
| st_done_mask | output | 4 | Lanes that completed |
| st_to_mask | output | 4 | Lanes that timed out |
| f_addr | output | 21 | Flash address bus |
| f_dq_out | output | 32 | Flash write data |
| f_dq_oe | output | 1 | Drive data bus |
| f_dq_in | input | 32 | Flash read data |
| f_we_n | output | 4 | Per-lane write strobes, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_rst_n | output | 1 | Device reset, active low |

## Verification
The assertions assume the following about the inputs. The host holds `rd_req` and `rd_addr` steady until `rd_ack` and then drops the request. `f_dq_in` changes only away from the rising clock edge. Timing parameters give at least one clock per minimum.

The stimulus drives every input on the falling edge. It releases `rd_req` in the same half cycle that it sees the acknowledge. A behavioural model of the devices answers status reads from the written bytes and holds each lane busy for a random number of cycles, or forever when a timeout is wanted. This keeps the returned data consistent with what was actually written.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WC_NS = 90,
  parameter int T_WP_NS = 45,
  parameter int T_WPH_NS = 20,
  parameter int T_OEH_NS = 10,
  parameter int T_RC_NS = 90,
  parameter int T_RP_NS = 500,
  parameter int T_READY_NS = 20000,
  parameter int TICK_NS = 1000,
  parameter int TO_PROG_TK = 300,
  parameter int TO_SECT_TK = 15000000,
  parameter int TO_CHIP_TK = 256000000,
  parameter logic [20:0] UA1 = 21'h555,
  parameter logic [20:0] UA2 = 21'h2AA,
  parameter logic [7:0] UD1 = 8'hAA,
  parameter logic [7:0] UD2 = 8'h55,
  parameter logic [7:0] CMD_PROG = 8'hA0,
  parameter logic [7:0] CMD_ERASE = 8'h80,
  parameter logic [7:0] CMD_SECT = 8'h30,
  parameter logic [7:0] CMD_CHIP = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [20:0] cmd_addr,
  input  logic [31:0] cmd_data,
  input  logic [3:0]  cmd_be,
  output logic        cmd_ready,
  input  logic        rd_req,
  input  logic [20:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_ack,
  output logic        st_done,
  output logic [3:0]  st_done_mask,
  output logic [3:0]  st_to_mask,
  output logic [20:0] f_addr,
  output logic [31:0] f_dq_out,
  output logic        f_dq_oe,
  input  logic [31:0] f_dq_in,
  output logic [3:0]  f_we_n,
  output logic        f_oe_n,
  output logic        f_rst_n
);
  function automatic int clks(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int C_WP  = clks(T_WP_NS);
  localparam int C_OEH = clks(T_OEH_NS);
  localparam int C_H0  = (clks(T_WC_NS) - C_WP > clks(T_WPH_NS)) ? clks(T_WC_NS) - C_WP : clks(T_WPH_NS);
  localparam int C_WH  = (C_H0 > C_OEH) ? C_H0 : C_OEH;
  localparam int C_RC  = clks(T_RC_NS);
  localparam int C_RP  = clks(T_RP_NS);
  localparam int C_RDY = clks(T_READY_NS);
  localparam int C_TK  = clks(TICK_NS);
  localparam int CMAX  = C_WP + C_WH + C_RC + C_RP + C_RDY + C_TK;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_RST = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_POLL, S_GAP, S_RD, S_RLO, S_RWT} st_t;
  st_t st;
  logic [CW-1:0] cnt, tick_pre;
  logic [31:0]   tick_cnt, limit;
  logic [2:0]    step;
  logic [1:0]    op;
  logic [20:0]   addr_r, seq_a;
  logic [31:0]   data_r;
  logic [7:0]    seq_d;
  logic [3:0]    be_r, lane_ok, exp7, hit;
  logic          ret_poll, timed, is_prog, last, wr, other_sec;

  assign is_prog = op == OP_PROG;
  assign last = is_prog ? (step == 3'd3) : (step == 3'd5);
  assign wr = (st == S_WLO) || (st == S_WHI);
  assign other_sec = (op == OP_SECT) && (rd_addr[20:16] != addr_r[20:16]);
  assign limit = is_prog ? 32'(TO_PROG_TK) : (op == OP_SECT) ? 32'(TO_SECT_TK) : 32'(TO_CHIP_TK);

  always_comb begin
    case (step)
      3'd0: begin seq_a = UA1; seq_d = UD1; end
      3'd1: begin seq_a = UA2; seq_d = UD2; end
      3'd2: begin seq_a = UA1; seq_d = is_prog ? CMD_PROG : CMD_ERASE; end
      3'd3: begin seq_a = is_prog ? addr_r : UA1; seq_d = UD1; end
      3'd4: begin seq_a = UA2; seq_d = UD2; end
      default: begin
        seq_a = (op == OP_SECT) ? {addr_r[20:16], 16'h0} : UA1;
        seq_d = (op == OP_SECT) ? CMD_SECT : CMD_CHIP;
      end
    endcase
    for (int l = 0; l < 4; l++) exp7[l] = is_prog ? data_r[8*l+7] : 1'b1;
  end

  assign hit = lane_ok | (be_r & ~({f_dq_in[31], f_dq_in[23], f_dq_in[15], f_dq_in[7]} ^ exp7));
  assign f_addr = (st == S_RD) ? rd_addr : (wr ? seq_a : addr_r);
  assign f_dq_out = (is_prog && step == 3'd3) ? data_r : {4{seq_d}};
  assign f_dq_oe = wr;
  assign f_we_n = (st == S_WLO) ? ~be_r : 4'hF;
  assign f_oe_n = !((st == S_POLL) || (st == S_RD));
  assign f_rst_n = st != S_RLO;
  assign cmd_ready = st == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tick_pre <= '0; tick_cnt <= '0; step <= '0; op <= '0;
      addr_r <= '0; data_r <= '0; be_r <= '0; lane_ok <= '0; ret_poll <= 1'b0; timed <= 1'b0;
      rd_data <= '0; rd_ack <= 1'b0; st_done <= 1'b0; st_done_mask <= '0; st_to_mask <= '0;
    end else begin
      st_done <= 1'b0;
      rd_ack <= 1'b0;
      if (st == S_POLL || st == S_GAP || (st == S_RD && ret_poll)) begin
        if (tick_pre == CW'(C_TK - 1)) begin tick_pre <= '0; tick_cnt <= tick_cnt + 1; end
        else tick_pre <= tick_pre + 1'b1;
      end
      case (st)
        S_IDLE:
          if (cmd_valid) begin
            op <= cmd_op; addr_r <= cmd_addr; data_r <= cmd_data; step <= '0;
            tick_pre <= '0; tick_cnt <= '0;
            if (cmd_op == OP_RST) begin timed <= 1'b0; st <= S_RLO; cnt <= CW'(C_RP - 1); end
            else begin
              be_r <= (cmd_op == OP_PROG) ? cmd_be : 4'hF;
              lane_ok <= (cmd_op == OP_PROG) ? ~cmd_be : 4'h0;
              st <= S_WLO; cnt <= CW'(C_WP - 1);
            end
          end else if (rd_req) begin ret_poll <= 1'b0; st <= S_RD; cnt <= CW'(C_RC - 1); end
        S_WLO:
          if (cnt == 0) begin st <= S_WHI; cnt <= CW'(C_WH - 1); end else cnt <= cnt - 1'b1;
        S_WHI:
          if (cnt != 0) cnt <= cnt - 1'b1;
          else if (last) begin st <= S_POLL; cnt <= CW'(C_RC - 1); end
          else begin step <= step + 1'b1; st <= S_WLO; cnt <= CW'(C_WP - 1); end
        S_POLL:
          if (cnt == 0) begin lane_ok <= hit; st <= S_GAP; end else cnt <= cnt - 1'b1;
        S_GAP:
          if (&lane_ok) begin
            st_done <= 1'b1; st_done_mask <= be_r; st_to_mask <= '0; st <= S_IDLE;
          end else if (tick_cnt >= limit) begin
            st_to_mask <= be_r & ~lane_ok; timed <= 1'b1; st <= S_RLO; cnt <= CW'(C_RP - 1);
          end else if (rd_req && other_sec) begin
            ret_poll <= 1'b1; st <= S_RD; cnt <= CW'(C_RC - 1);
          end else begin st <= S_POLL; cnt <= CW'(C_RC - 1); end
        S_RD:
          if (cnt == 0) begin
            rd_data <= f_dq_in; rd_ack <= 1'b1; st <= ret_poll ? S_GAP : S_IDLE;
          end else cnt <= cnt - 1'b1;
        S_RLO:
          if (cnt == 0) begin st <= S_RWT; cnt <= CW'(C_RDY - 1); end else cnt <= cnt - 1'b1;
        default:
          if (cnt == 0) begin
            st_done <= 1'b1;
            st_done_mask <= timed ? (lane_ok & be_r) : 4'hF;
            if (!timed) st_to_mask <= '0;
            st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  logic [CW-1:0] a_lo, a_hi, a_rp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin a_lo <= '0; a_hi <= CW'(CMAX); a_rp <= '0; end
    else begin
      a_lo <= (&f_we_n) ? '0 : a_lo + 1'b1;
      a_hi <= (&f_we_n) ? ((a_hi == CW'(CMAX)) ? a_hi : a_hi + 1'b1) : '0;
      a_rp <= f_rst_n ? '0 : a_rp + 1'b1;
    end
  end

  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(&f_we_n) |-> a_lo >= CW'(C_WP)); // R3
  AST_WE_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(&f_we_n) |-> a_hi >= CW'(C_WH)); // R3
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(f_oe_n) |-> a_hi >= CW'(C_OEH)); // R6
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!f_oe_n && !(&f_we_n))); // R6
  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(f_rst_n) |-> a_rp >= CW'(C_RP)); // R7
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !f_rst_n |-> (&f_we_n) && f_oe_n); // R8
  AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) st_done |-> (st_done_mask & st_to_mask) == 4'h0); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && cmd_ready |=> !cmd_ready); // R10
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int CLK_NS = 10;
  localparam int C_WP = 5, C_WH = 4, C_RP = 50, C_RDY = 200, TO_PROG_CYC = 500;

  logic clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0, rd_req = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [20:0] cmd_addr = '0, rd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic [3:0] cmd_be = '0;
  logic cmd_ready, rd_ack, st_done, f_dq_oe, f_oe_n, f_rst_n;
  logic [31:0] rd_data, f_dq_out, f_dq_in;
  logic [3:0] st_done_mask, st_to_mask, f_we_n;
  logic [20:0] f_addr;

  flash_seq #(.CLK_PERIOD_NS(CLK_NS), .T_READY_NS(2000), .TICK_NS(100),
              .TO_PROG_TK(50), .TO_SECT_TK(80), .TO_CHIP_TK(100)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_be(cmd_be), .cmd_ready(cmd_ready), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ack(rd_ack), .st_done(st_done), .st_done_mask(st_done_mask),
    .st_to_mask(st_to_mask), .f_addr(f_addr), .f_dq_out(f_dq_out), .f_dq_oe(f_dq_oe),
    .f_dq_in(f_dq_in), .f_we_n(f_we_n), .f_oe_n(f_oe_n), .f_rst_n(f_rst_n));

  int errs = 0, checks = 0, cyc_n = 0;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [20:0] a);
    return ({11'h0, a} * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  int busy[4], cnt_c[4], dur[4], ovk[4], ln[4], lo[4];
  bit kprog[4], eras[4];
  bit [3:0] e7, stuck = '0;
  logic [4:0] esec[4];
  logic [20:0] wa[4], fa[4];
  logic [7:0] wb[4];
  logic [20:0] la[4][8];
  logic [7:0] ld[4][8];

  always_comb begin
    logic [31:0] m;
    m = memf(f_addr);
    for (int l = 0; l < 4; l++) begin
      if (busy[l] != 0 && !(eras[l] && f_addr[20:16] != esec[l])) f_dq_in[8*l+:8] = {~e7[l], 7'h2A};
      else if (ovk[l] == 1 && f_addr == wa[l]) f_dq_in[8*l+:8] = wb[l];
      else if ((ovk[l] == 2 && f_addr[20:16] == esec[l]) || ovk[l] == 3) f_dq_in[8*l+:8] = 8'hFF;
      else f_dq_in[8*l+:8] = m[8*l+:8];
    end
  end

  logic [3:0] pwe = 4'hF;
  logic poe = 1'b1, prst = 1'b1;
  int hi = 1000, rplo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 4; l++) begin
        if (pwe[l] && !f_we_n[l]) begin
          chk(hi >= C_WH, "R3", "strobe high gap", hi, C_WH);
          lo[l] = 1; fa[l] = f_addr;
        end else if (!f_we_n[l]) begin
          lo[l]++;
          if (f_addr != fa[l]) chk(1'b0, "R3", "address moved under strobe", f_addr, fa[l]);
        end else if (!pwe[l]) begin
          logic [7:0] d;
          d = f_dq_out[8*l+:8];
          chk(lo[l] >= C_WP, "R3", "strobe low width", lo[l], C_WP);
          if (ln[l] < 8) begin la[l][ln[l]] = f_addr; ld[l][ln[l]] = d; end
          ln[l]++; cnt_c[l]++;
          if (cnt_c[l] == 3) kprog[l] = (d == 8'hA0);
          if ((kprog[l] && cnt_c[l] == 4) || (!kprog[l] && cnt_c[l] == 6)) begin
            e7[l] = kprog[l] ? d[7] : 1'b1;
            eras[l] = !kprog[l] && d == 8'h30;
            esec[l] = f_addr[20:16];
            wa[l] = f_addr; wb[l] = d;
            ovk[l] = kprog[l] ? 1 : (eras[l] ? 2 : 3);
            busy[l] = stuck[l] ? -1 : dur[l];
            cnt_c[l] = 0;
          end
        end
      end
      if (poe && !f_oe_n) chk(hi >= 1, "R6", "output enable hold", hi, 1);
      if (!f_oe_n && f_we_n != 4'hF) chk(1'b0, "R6", "strobe and oe both low", f_we_n, 4'hF);
      if (&f_we_n) hi++; else hi = 0;
      if (prst && !f_rst_n) rplo = 0;
      if (!f_rst_n) begin
        rplo++;
        for (int l = 0; l < 4; l++) begin busy[l] = 0; cnt_c[l] = 0; end
      end
      if (!prst && f_rst_n) chk(rplo >= C_RP, "R7", "reset pulse width", rplo, C_RP);
      for (int l = 0; l < 4; l++) if (busy[l] > 0) busy[l]--;
      pwe = f_we_n; poe = f_oe_n; prst = f_rst_n;
    end
  end

  int last_lat, last_done_t;

  task automatic run_cmd(input logic [1:0] op, input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
    int t0, n;
    for (int l = 0; l < 4; l++) ln[l] = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_be = be;
    @(negedge clk);
    cmd_valid = 1'b0;
    t0 = cyc_n; n = 0;
    while (!st_done && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(1'b0, "R5", "operation never ended", 0, 1);
    last_lat = cyc_n - t0; last_done_t = cyc_n;
  endtask

  task automatic do_read(input logic [20:0] a, output logic [31:0] d, output int t);
    int n;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; n = 0;
    @(negedge clk);
    while (!rd_ack && n < 5000) begin @(negedge clk); n++; end
    d = rd_data; t = cyc_n; rd_req = 1'b0;
  endtask

  function automatic logic [28:0] expc(input int op, input int s, input logic [20:0] a, input logic [7:0] d);
    case (s)
      0: return {21'h555, 8'hAA};
      1: return {21'h2AA, 8'h55};
      2: return {21'h555, (op == 0) ? 8'hA0 : 8'h80};
      3: return (op == 0) ? {a, d} : {21'h555, 8'hAA};
      4: return {21'h2AA, 8'h55};
      default: return (op == 1) ? {a[20:16], 16'h0, 8'h30} : {21'h555, 8'h10};
    endcase
  endfunction

  task automatic check_log(input int op, input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
    int n;
    string tag;
    n = (op == 0) ? 4 : 6;
    tag = (op == 0) ? "R2" : "R4";
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        chk(ln[l] == n, tag, "write cycle count", ln[l], n);
        for (int s = 0; s < n && s < ln[l]; s++)
          chk({la[l][s], ld[l][s]} == expc(op, s, a, d[8*l+:8]), tag, "write cycle", {la[l][s], ld[l][s]}, expc(op, s, a, d[8*l+:8]));
      end else chk(ln[l] == 0, "R2", "disabled lane strobed", ln[l], 0);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_NS * 190000);
    chk(1'b0, "WD", "watchdog expired", cyc_n, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd, a32, d32;
    int tr, mx;
    logic [3:0] be;
    void'($urandom(32'd2024));
    for (int l = 0; l < 4; l++) begin busy[l] = 0; cnt_c[l] = 0; ovk[l] = 0; ln[l] = 0; dur[l] = 30; end
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(f_we_n == 4'hF && f_oe_n && f_rst_n, "R1", "bus idle after reset", {f_we_n, f_oe_n, f_rst_n}, 6'h3F);
    chk(st_done_mask == 0 && st_to_mask == 0 && !rd_ack, "R1", "status after reset", {st_done_mask, st_to_mask, rd_ack}, 0);
    rst_n = 1'b1;

    do_read(21'h1ABCD, rd, tr);
    chk(rd == memf(21'h1ABCD), "R9", "idle read data", rd, memf(21'h1ABCD));

    dur[0] = 40; dur[1] = 260; dur[2] = 90; dur[3] = 20;
    run_cmd(2'd0, 21'h12345, 32'h807F01FE, 4'hF);
    check_log(0, 21'h12345, 32'h807F01FE, 4'hF);
    chk(st_done_mask == 4'hF && st_to_mask == 0, "R5", "program status", {st_done_mask, st_to_mask}, 8'hF0);
    chk(last_lat >= 260, "R5", "done before slowest lane", last_lat, 260);

    fork
      run_cmd(2'd0, 21'h00F0F, 32'h11223344, 4'b0101);
      begin
        repeat (40) @(negedge clk);
        chk(cmd_ready == 1'b0, "R10", "ready while busy", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    check_log(0, 21'h00F0F, 32'h11223344, 4'b0101);
    chk(st_done_mask == 4'b0101, "R5", "partial lane mask", st_done_mask, 4'b0101);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && f_we_n == 4'hF, "R10", "busy request dropped", {cmd_ready, f_we_n}, 5'h1F);

    for (int l = 0; l < 4; l++) dur[l] = 200 + 20 * l;
    fork
      run_cmd(2'd1, 21'h0A1234, 32'h0, 4'h0);
      begin repeat (80) @(negedge clk); do_read(21'h031111, rd, tr); end
    join
    check_log(1, 21'h0A1234, 32'h0, 4'hF);
    chk(tr < last_done_t, "R9", "other-sector read served during erase", tr, last_done_t);
    chk(rd == memf(21'h031111), "R9", "other-sector read data", rd, memf(21'h031111));
    chk(st_done_mask == 4'hF && st_to_mask == 0, "R5", "sector erase status", {st_done_mask, st_to_mask}, 8'hF0);

    fork
      run_cmd(2'd1, 21'h0A0000, 32'h0, 4'h0);
      begin repeat (80) @(negedge clk); do_read(21'h0A7777, rd, tr); end
    join
    chk(tr > last_done_t, "R9", "same-sector read held", tr, last_done_t);
    chk(rd == 32'hFFFFFFFF, "R9", "erased sector data", rd, 32'hFFFFFFFF);

    fork
      run_cmd(2'd2, 21'h1F0000, 32'h0, 4'h0);
      begin repeat (80) @(negedge clk); do_read(21'h055555, rd, tr); end
    join
    check_log(2, 21'h1F0000, 32'h0, 4'hF);
    chk(tr > last_done_t, "R9", "read held during bank erase", tr, last_done_t);
    chk(rd == 32'hFFFFFFFF, "R9", "bank erased data", rd, 32'hFFFFFFFF);

    for (int l = 0; l < 4; l++) dur[l] = 50;
    stuck = 4'b0100;
    run_cmd(2'd0, 21'h00100, 32'hA5A5A5A5, 4'hF);
    chk(st_to_mask == 4'b0100, "R7", "timeout mask", st_to_mask, 4'b0100);
    chk(st_done_mask == 4'b1011, "R7", "finished lanes after timeout", st_done_mask, 4'b1011);
    chk(last_lat >= TO_PROG_CYC + C_RP + C_RDY, "R7", "timeout recovery length", last_lat, TO_PROG_CYC + C_RP + C_RDY);
    stuck = 4'b0000;

    run_cmd(2'd3, 21'h0, 32'h0, 4'h0);
    chk(st_done_mask == 4'hF && st_to_mask == 0, "R8", "reset request status", {st_done_mask, st_to_mask}, 8'hF0);
    chk(ln[0] + ln[1] + ln[2] + ln[3] == 0, "R8", "reset issued writes", ln[0] + ln[1] + ln[2] + ln[3], 0);
    chk(last_lat >= C_RP + C_RDY, "R8", "reset recovery length", last_lat, C_RP + C_RDY);

    for (int i = 0; i < 8; i++) begin
      a32 = $urandom; d32 = $urandom; be = 4'($urandom);
      mx = 0;
      for (int l = 0; l < 4; l++) begin
        dur[l] = 20 + int'($urandom % 280);
        if (be[l] && dur[l] > mx) mx = dur[l];
      end
      run_cmd(2'd0, a32[20:0], d32, be);
      check_log(0, a32[20:0], d32, be);
      chk(st_done_mask == be && st_to_mask == 0, "R5", "random program status", {st_done_mask, st_to_mask}, {be, 4'h0});
      chk(last_lat >= mx, "R5", "random done latency", last_lat, mx);
      do_read(a32[20:0], rd, tr);
      for (int l = 0; l < 4; l++)
        if (be[l]) chk(rd[8*l+:8] == d32[8*l+:8], "R9", "readback programmed byte", rd[8*l+:8], d32[8*l+:8]);
    end

    for (int i = 0; i < 3; i++) begin
      a32 = $urandom;
      for (int l = 0; l < 4; l++) dur[l] = 20 + int'($urandom % 400);
      run_cmd(2'd1, a32[20:0], 32'h0, 4'h0);
      check_log(1, a32[20:0], 32'h0, 4'hF);
      chk(st_done_mask == 4'hF, "R5", "random erase status", st_done_mask, 4'hF);
    end

    summary();
    $finish;
  end
endmodule